// File: doc/BRIEF.md
# Masked Chip-Select Address Decoder

This block turns a bus access into one of two chip-select strobes. Each region holds a 16-bit base value, a 16-bit don't-care mask, a write-protect flag, a valid flag and a set of timing fields. On every access request, the upper 16 address bits are compared with each region's base. Bits set in the mask are ignored in that comparison, so a region can cover several separate address windows. The region size is 2^(16 + number of mask bits set) bytes.

A write that lands in a write-protected region is refused. The block raises a bus error and asserts no chip-select. The timing fields of the selected region (wait states, auto-acknowledge, port size, multiplexed mode, address setup, read hold and write hold) are driven on outputs, for use by a separate bus sequencer.

Software programs the regions through a small synchronous register port. All chip-selects stay off after reset until region 0 has been marked valid at least once.

Top module: `cs_addr_decoder`

## Requirements
- R1: After reset, the decode outputs are all zero, and the base and mask registers of both regions read 0. Region 0's control register reads 0x003F_FD40 and region 1's reads 0x0000_0000.
- R2: Register offsets are as follows. Region 0 uses 0x00 for base, 0x04 for mask and 0x08 for control. Region 1 uses 0x0C, 0x10 and 0x14 in the same order. The mask register keeps bits 31:16 (mask), bit 8 (write protect) and bit 0 (valid). The base register keeps bits 31:16. The control register keeps bits 21:6. All other bits read 0, so writing all ones reads back 0xFFFF_0101, 0xFFFF_0000 and 0x003F_FFC0 respectively.
- R3: A region matches when every address bit 31:16 whose mask bit is 0 equals the base bit. Bits with a mask bit of 1 are ignored, so base 0x0040 with mask 0x0008 selects 0x0040_xxxx and 0x0048_xxxx but not 0x0044_xxxx.
- R4: A region whose valid bit is clear never asserts its chip-select.
- R5: No chip-select asserts until region 0's valid bit has been set once since reset. After that, clearing region 0's valid bit does not stop region 1 from decoding.
- R6: A write to the selected region when its write-protect bit is set gives bus_err_o=1 and cs_o=0. A read of that region asserts its chip-select. A region without write protect accepts writes.
- R7: When both regions match, only region 0's chip-select (cs_o bit 0) asserts. At most one cs_o bit is ever high.
- R8: The outputs are registered and reflect the access presented with acc_req one clock earlier. In a cycle after one with acc_req low, cs_o is 0 and bus_err_o is 0.
- R9: When a chip-select asserts, the field outputs carry that region's control fields: ASET 21:20, RDAH 19:18, WRAH 17:16, WS 15:10, MUX 9, AA 8 and PS 7:6. With no chip-select, every field output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_ofs | input | 5 | Register byte offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the register at reg_ofs |
| acc_req | input | 1 | Bus access request strobe |
| acc_write | input | 1 | Access is a write |
| acc_addr | input | 32 | Access address |
| cs_o | output | 2 | Chip-select per region, active high |
| bus_err_o | output | 1 | Write-protect bus error |
| aset_o | output | 2 | Address setup field of the selected region |
| rdah_o | output | 2 | Read address hold field |
| wrah_o | output | 2 | Write address hold field |
| ws_o | output | 6 | Wait-state count field |
| mux_o | output | 1 | Multiplexed-bus field |
| aa_o | output | 1 | Auto-acknowledge field |
| ps_o | output | 2 | Port size field |

## Verification
The hardest state to reach from the ports is an armed decoder in which region 0 is no longer valid but region 1 still decodes. It also needs the contrasting case: a fresh reset in which region 1 alone is valid and must stay silent. The stimulus reaches both. It sets region 0 valid, then clears it and decodes through region 1. It then applies a second reset and programs only region 1. Overlapping regions, where the region with write protect loses on priority, are built by reprogramming region 1 onto region 0's window.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;

  localparam int CMP_W = 16;
  localparam int CTRL_W = 16;
  localparam logic [31:0] CS_CTRL0_RST = 32'h003F_FD40;

  typedef struct packed {
    logic [1:0] aset;
    logic [1:0] rdah;
    logic [1:0] wrah;
    logic [5:0] ws;
    logic       mux;
    logic       aa;
    logic [1:0] ps;
  } cs_ctrl_t;

  typedef struct packed {
    logic [CMP_W-1:0] base;
    logic [CMP_W-1:0] mask;
    logic             wp;
    logic             valid;
    cs_ctrl_t         ctrl;
  } cs_region_t;

  function automatic logic region_hit(input logic [CMP_W-1:0] addr_hi,
                                      input logic [CMP_W-1:0] base,
                                      input logic [CMP_W-1:0] mask);
    return ((addr_hi ^ base) & ~mask) == '0;
  endfunction

  function automatic logic [31:0] base_word(input logic [CMP_W-1:0] base);
    return {base, 16'h0000};
  endfunction

  function automatic logic [31:0] mask_word(input logic [CMP_W-1:0] mask,
                                            input logic wp, input logic valid);
    return {mask, 7'b0, wp, 7'b0, valid};
  endfunction

  function automatic logic [31:0] ctrl_word(input cs_ctrl_t c);
    return {10'b0, c, 6'b0};
  endfunction

  function automatic cs_ctrl_t ctrl_field(input logic [31:0] w);
    return cs_ctrl_t'(w[21:6]);
  endfunction

endpackage

// File: rtl/cs_region_regs.sv
module cs_region_regs
  import cs_dec_pkg::*;
#(
  parameter int          REG_IDX  = 0,
  parameter int          OFS_W    = 5,
  parameter logic [31:0] CTRL_RST = 32'h0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] ofs,
  input  logic [31:0]      wdata,
  output cs_region_t       region,
  output logic [31:0]      rd_data
);

  localparam int BASE_OFS = REG_IDX * 12;
  localparam logic [OFS_W-1:0] OFS_B = OFS_W'(BASE_OFS);
  localparam logic [OFS_W-1:0] OFS_M = OFS_W'(BASE_OFS + 4);
  localparam logic [OFS_W-1:0] OFS_C = OFS_W'(BASE_OFS + 8);

  logic sel_b, sel_m, sel_c;
  logic unused_wbits;

  assign sel_b = (ofs == OFS_B);
  assign sel_m = (ofs == OFS_M);
  assign sel_c = (ofs == OFS_C);
  assign unused_wbits = ^{wdata[15:9], wdata[7:1], wdata[5:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      region.base  <= '0;
      region.mask  <= '0;
      region.wp    <= 1'b0;
      region.valid <= 1'b0;
      region.ctrl  <= ctrl_field(CTRL_RST);
    end else if (wr_en) begin
      if (sel_b) region.base <= wdata[31:16];
      if (sel_m) begin
        region.mask  <= wdata[31:16];
        region.wp    <= wdata[8];
        region.valid <= wdata[0];
      end
      if (sel_c) region.ctrl <= ctrl_field(wdata);
    end
  end

  always_comb begin
    rd_data = '0;
    if (sel_b) rd_data = base_word(region.base);
    if (sel_m) rd_data = mask_word(region.mask, region.wp, region.valid);
    if (sel_c) rd_data = ctrl_word(region.ctrl);
  end

endmodule

// File: rtl/cs_region_match.sv
module cs_region_match
  import cs_dec_pkg::*;
(
  input  logic [CMP_W-1:0] addr_hi,
  input  logic [CMP_W-1:0] base,
  input  logic [CMP_W-1:0] mask,
  input  logic             valid,
  input  logic             armed,
  output logic             hit
);

  assign hit = armed & valid & region_hit(addr_hi, base, mask);

endmodule

// File: rtl/cs_prio_pick.sv
module cs_prio_pick #(
  parameter int N = 2
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);

  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/cs_addr_decoder.sv
module cs_addr_decoder
  import cs_dec_pkg::*;
#(
  parameter int NUM_REGIONS = 2,
  parameter int ADDR_W      = 32,
  parameter int OFS_W       = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic [OFS_W-1:0]       reg_ofs,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  input  logic                   acc_req,
  input  logic                   acc_write,
  input  logic [ADDR_W-1:0]      acc_addr,
  output logic [NUM_REGIONS-1:0] cs_o,
  output logic                   bus_err_o,
  output logic [1:0]             aset_o,
  output logic [1:0]             rdah_o,
  output logic [1:0]             wrah_o,
  output logic [5:0]             ws_o,
  output logic                   mux_o,
  output logic                   aa_o,
  output logic [1:0]             ps_o
);

  localparam int LOW_W = ADDR_W - CMP_W;

  cs_region_t                   rgn      [NUM_REGIONS];
  logic       [31:0]            rd_part  [NUM_REGIONS];
  logic       [NUM_REGIONS-1:0] hit_vec;
  logic       [NUM_REGIONS-1:0] grant;
  logic       [NUM_REGIONS-1:0] valid_vec;
  logic       [NUM_REGIONS-1:0] wp_vec;
  logic       [CMP_W-1:0]       addr_hi;
  logic                         armed_q, armed_now;
  logic                         wp_block;
  cs_ctrl_t                     sel_ctrl;
  logic       [NUM_REGIONS-1:0] cs_d;
  cs_ctrl_t                     ctrl_d, ctrl_q;
  logic                         unused_addr;

  assign addr_hi     = acc_addr[ADDR_W-1 -: CMP_W];
  assign unused_addr = ^acc_addr[LOW_W-1:0];

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    cs_region_regs #(
      .REG_IDX (g),
      .OFS_W   (OFS_W),
      .CTRL_RST((g == 0) ? CS_CTRL0_RST : 32'h0)
    ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (reg_wr),
      .ofs    (reg_ofs),
      .wdata  (reg_wdata),
      .region (rgn[g]),
      .rd_data(rd_part[g])
    );

    cs_region_match u_match (
      .addr_hi(addr_hi),
      .base   (rgn[g].base),
      .mask   (rgn[g].mask),
      .valid  (rgn[g].valid),
      .armed  (armed_now),
      .hit    (hit_vec[g])
    );

    assign valid_vec[g] = rgn[g].valid;
    assign wp_vec[g]    = rgn[g].wp;
  end

  cs_prio_pick #(.N(NUM_REGIONS)) u_pick (
    .req  (hit_vec),
    .grant(grant)
  );

  // Sticky enable: opens once region 0 has been valid, stays open until reset.
  assign armed_now = armed_q | rgn[0].valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_now;
  end

  always_comb begin
    reg_rdata = '0;
    sel_ctrl  = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      reg_rdata = reg_rdata | rd_part[i];
      if (grant[i]) sel_ctrl = sel_ctrl | rgn[i].ctrl;
    end
  end

  assign wp_block = acc_write & |(grant & wp_vec);
  assign cs_d     = wp_block ? '0 : grant;
  assign ctrl_d   = (|cs_d) ? sel_ctrl : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_o      <= '0;
      bus_err_o <= 1'b0;
      ctrl_q    <= '0;
    end else if (acc_req) begin
      cs_o      <= cs_d;
      bus_err_o <= wp_block;
      ctrl_q    <= ctrl_d;
    end else begin
      cs_o      <= '0;
      bus_err_o <= 1'b0;
      ctrl_q    <= '0;
    end
  end

  assign aset_o = ctrl_q.aset;
  assign rdah_o = ctrl_q.rdah;
  assign wrah_o = ctrl_q.wrah;
  assign ws_o   = ctrl_q.ws;
  assign mux_o  = ctrl_q.mux;
  assign aa_o   = ctrl_q.aa;
  assign ps_o   = ctrl_q.ps;

endmodule

// File: rtl/cs_dec_checker.sv
module cs_dec_checker #(
  parameter int NUM_REGIONS = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   acc_req,
  input logic                   acc_write,
  input logic [NUM_REGIONS-1:0] cs_o,
  input logic                   bus_err_o,
  input logic                   armed,
  input logic [NUM_REGIONS-1:0] valid_vec,
  input logic                   wp_block
);

  p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_o));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_req |=> (cs_o == '0 && !bus_err_o));

  p_err_no_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err_o |-> (cs_o == '0));

  p_wp_error_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && acc_write && wp_block) |=> bus_err_o);

  p_unarmed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (cs_o == '0));

  p_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req |=> ((cs_o & ~$past(valid_vec)) == '0));

endmodule

bind cs_addr_decoder cs_dec_checker #(.NUM_REGIONS(NUM_REGIONS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .acc_req  (acc_req),
  .acc_write(acc_write),
  .cs_o     (cs_o),
  .bus_err_o(bus_err_o),
  .armed    (armed_now),
  .valid_vec(valid_vec),
  .wp_block (wp_block)
);

// File: tb/test_cs_addr_decoder.sv
module test_cs_addr_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_ofs = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        acc_req = 1'b0;
  logic        acc_write = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [1:0]  cs_o;
  logic        bus_err_o;
  logic [1:0]  aset_o, rdah_o, wrah_o, ps_o;
  logic [5:0]  ws_o;
  logic        mux_o, aa_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  localparam logic [31:0] CTRL0 = 32'h003F_FD40;
  localparam logic [31:0] CTRL1 = 32'h0027_1680;

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [1:0]  cs;
    logic        err;
    logic [1:0]  sel;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 32'h0040_1234, 2'b01, 1'b0, 2'd1},
    '{1'b0, 32'h0048_FFFF, 2'b01, 1'b0, 2'd1},
    '{1'b0, 32'h0044_0000, 2'b00, 1'b0, 2'd0},
    '{1'b1, 32'h0040_0000, 2'b01, 1'b0, 2'd1},
    '{1'b0, 32'h006A_0000, 2'b10, 1'b0, 2'd2},
    '{1'b1, 32'h0065_0000, 2'b00, 1'b1, 2'd0},
    '{1'b0, 32'h0070_0000, 2'b00, 1'b0, 2'd0},
    '{1'b0, 32'h0140_0000, 2'b00, 1'b0, 2'd0}
  };

  always #2 clk = ~clk;

  cs_addr_decoder i_cs_addr_decoder (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_ofs(reg_ofs),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_req(acc_req),
    .acc_write(acc_write), .acc_addr(acc_addr), .cs_o(cs_o),
    .bus_err_o(bus_err_o), .aset_o(aset_o), .rdah_o(rdah_o),
    .wrah_o(wrah_o), .ws_o(ws_o), .mux_o(mux_o), .aa_o(aa_o), .ps_o(ps_o)
  );

  function automatic logic [15:0] fields_of(input logic [31:0] w);
    return w[21:6];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [4:0] ofs, input logic [31:0] data);
    @(negedge clk);
    reg_wr = 1'b1; reg_ofs = ofs; reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_check(input string tag, input logic [4:0] ofs, input logic [31:0] exp);
    @(negedge clk);
    reg_ofs = ofs;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic access(input logic wr, input logic [31:0] addr);
    @(negedge clk);
    acc_req = 1'b1; acc_write = wr; acc_addr = addr;
    @(negedge clk);
    acc_req = 1'b0; acc_write = 1'b0;
  endtask

  task automatic out_check(input string tag, input logic [1:0] cs, input logic err,
                           input logic [15:0] fld);
    chk({tag, " cs"}, {30'b0, cs_o}, {30'b0, cs});
    chk({tag, " err"}, {31'b0, bus_err_o}, {31'b0, err});
    chk({tag, " fields"}, {16'b0, aset_o, rdah_o, wrah_o, ws_o, mux_o, aa_o, ps_o},
        {16'b0, fld});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] f;
    do_reset();
    // R1 reset state
    out_check("R1 outputs", 2'b00, 1'b0, 16'h0);
    reg_check("R1 base0", 5'h00, 32'h0);
    reg_check("R1 mask0", 5'h04, 32'h0);
    reg_check("R1 ctrl0", 5'h08, CTRL0);
    reg_check("R1 base1", 5'h0C, 32'h0);
    reg_check("R1 mask1", 5'h10, 32'h0);
    reg_check("R1 ctrl1", 5'h14, 32'h0);

    // R2 reserved bits
    reg_write(5'h0C, 32'hFFFF_FFFF);
    reg_write(5'h10, 32'hFFFF_FFFF);
    reg_write(5'h14, 32'hFFFF_FFFF);
    reg_check("R2 base1", 5'h0C, 32'hFFFF_0000);
    reg_check("R2 mask1", 5'h10, 32'hFFFF_0101);
    reg_check("R2 ctrl1", 5'h14, 32'h003F_FFC0);
    reg_check("R2 base0 untouched", 5'h00, 32'h0);

    // Program: region0 base 0x0040 mask 0x0008 valid; region1 0x0060/0x000F wp valid
    reg_write(5'h00, 32'h0040_0000);
    reg_write(5'h04, 32'h0008_0001);
    reg_write(5'h0C, 32'h0060_0000);
    reg_write(5'h10, 32'h000F_0101);
    reg_write(5'h14, CTRL1);
    reg_check("R2 ctrl1 prog", 5'h14, CTRL1);

    // Table walk: R3 R6 R9
    for (int i = 0; i < 8; i++) begin
      access(VECS[i].wr, VECS[i].addr);
      f = (VECS[i].sel == 2'd1) ? fields_of(CTRL0) :
          (VECS[i].sel == 2'd2) ? fields_of(CTRL1) : 16'h0;
      out_check($sformatf("R3/R6/R9 vec%0d", i), VECS[i].cs, VECS[i].err, f);
    end

    // R8 idle cycle after a hit
    access(1'b0, 32'h0040_0000);
    out_check("R8 hit", 2'b01, 1'b0, fields_of(CTRL0));
    @(negedge clk);
    out_check("R8 idle", 2'b00, 1'b0, 16'h0);

    // R7 overlap: region1 covers 0x00xx with wp
    reg_write(5'h0C, 32'h0040_0000);
    reg_write(5'h10, 32'h00FF_0101);
    access(1'b0, 32'h0048_0000);
    out_check("R7 overlap read", 2'b01, 1'b0, fields_of(CTRL0));
    access(1'b1, 32'h0040_0000);
    out_check("R7 overlap write", 2'b01, 1'b0, fields_of(CTRL0));
    access(1'b0, 32'h0050_0000);
    out_check("R7 region1 only", 2'b10, 1'b0, fields_of(CTRL1));

    // R4 clear region0 valid, R5 region1 still works
    reg_write(5'h04, 32'h0008_0000);
    access(1'b0, 32'h0040_0000);
    out_check("R4 invalid region0", 2'b10, 1'b0, fields_of(CTRL1));
    access(1'b0, 32'h0150_0000);
    out_check("R4 no match", 2'b00, 1'b0, 16'h0);
    reg_write(5'h10, 32'h00FF_0000);
    access(1'b0, 32'h0050_0000);
    out_check("R4 invalid region1", 2'b00, 1'b0, 16'h0);
    reg_write(5'h10, 32'h00FF_0001);
    access(1'b0, 32'h0050_0000);
    out_check("R5 still armed", 2'b10, 1'b0, fields_of(CTRL1));

    // R5 fresh reset: region1 alone must not decode
    do_reset();
    reg_write(5'h0C, 32'h0060_0000);
    reg_write(5'h10, 32'h000F_0001);
    access(1'b0, 32'h0061_0000);
    out_check("R5 unarmed", 2'b00, 1'b0, 16'h0);
    reg_write(5'h04, 32'h0000_0001);
    access(1'b0, 32'h0061_0000);
    out_check("R5 armed", 2'b10, 1'b0, 16'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule